// File: doc/BRIEF.md
# Interrupt Controller with Normal and Fast Outputs

The block collects a vector of level-type interrupt sources and presents them to a processor on two active-high outputs: a normal interrupt line and a fast interrupt line. Software reaches it through a small register bus. It sets and clears the per-source enable mask through two separate write-one registers. A mode register steers each source to one of the two outputs. A polarity register lets a fixed set of external lines run active-low. A status register shows which enabled sources are pending.

External lines pass through a two-flop synchronizer before polarity is applied. For testing, a select bit replaces the live lines with a register that software writes. Pending state is level-based: a source stays pending for as long as its input stays asserted. No latched or edge state is kept.

Top module: `irq_fiq_ctrl`

## Requirements
- R1: Writing offset 1 sets every enable bit whose write-data bit is 1 and leaves the other enable bits unchanged. Reading offset 1 returns the current enable mask.
- R2: Writing offset 2 clears every enable bit whose write-data bit is 1 and leaves the other enable bits unchanged. Reading offset 2 also returns the mask. A single all-ones write masks every source.
- R3: Reading offset 0 returns the pending vector ANDed with the enable mask.
- R4: Offset 3 is the mode register (read/write). `irq_o` is the OR of enabled pending sources whose mode bit is 0. `fiq_o` is the OR of enabled pending sources whose mode bit is 1.
- R5: Offset 4 is the polarity register (read/write, 1 = active-low). It inverts a synchronized line only for sources named in the LOW_OK_MASK parameter, which by default names sources 4 and 6. For every other source the stored bit has no effect.
- R6: After reset, the enable, mode, polarity, select and test registers are 0, and `irq_o`, `fiq_o` and `rvalid_o` are low.
- R7: Offset 5 bit 0 is the source select and offset 6 is the test-source register. When the select bit is 1, the test bits become the pending vector from the next cycle on. They are active-high, the polarity register does not apply to them, and the live lines are ignored.
- R8: A change on `src_i` reaches the pending vector after the second rising clock edge; the outputs do not move after the first edge.
- R9: A read request sampled at a clock edge drives `rdata_o` and raises `rvalid_o` for one cycle right after that edge. Offset 7 reads as 0. A write takes effect at the edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | Raw interrupt lines |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register word offset |
| wdata_i | input | NUM_SRC | Write data |
| rdata_o | output | NUM_SRC | Read data |
| rvalid_o | output | 1 | Read data valid |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
Register writes show on `irq_o` and `fiq_o` in the same cycle as the edge that accepts them. The bench therefore checks the outputs at the falling edge right after each write. A change on a live line needs two rising edges. The bench checks after the first edge that nothing has moved yet, and after the second edge that the change has arrived. Before any status read that depends on a live line, it waits three edges. Read data is due one edge after the request. The driver queues the expected word when it issues the read, and the monitor pops and compares the word at the falling edge where `rvalid_o` is high.

// File: rtl/irq_fiq_pkg.sv
package irq_fiq_pkg;
  localparam int unsigned REG_AW = 3;
  typedef enum logic [REG_AW-1:0] {
    OFS_STATUS = 3'd0,
    OFS_EN_SET = 3'd1,
    OFS_EN_CLR = 3'd2,
    OFS_MODE   = 3'd3,
    OFS_LEVEL  = 3'd4,
    OFS_SEL    = 3'd5,
    OFS_TEST   = 3'd6,
    OFS_NONE   = 3'd7
  } reg_ofs_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= d_i[i];
        s2_q <= s1_q;
      end
    end
    assign q_o[i] = s2_q;
  end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_fiq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [REG_AW-1:0]  addr_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  input  logic [NUM_SRC-1:0] status_i,
  output logic [NUM_SRC-1:0] en_o,
  output logic [NUM_SRC-1:0] mode_o,
  output logic [NUM_SRC-1:0] level_o,
  output logic               sel_o,
  output logic [NUM_SRC-1:0] test_o,
  output logic [NUM_SRC-1:0] rdata_o,
  output logic               rvalid_o
);
  reg_ofs_e             ofs;
  logic [NUM_SRC-1:0]   en_q, mode_q, level_q, test_q, rd_mux, rdata_q;
  logic                 sel_q, rvalid_q;

  assign ofs = reg_ofs_e'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '0;
      mode_q  <= '0;
      level_q <= '0;
      sel_q   <= 1'b0;
      test_q  <= '0;
    end else if (wr_en_i) begin
      unique case (ofs)
        OFS_EN_SET: en_q    <= en_q | wdata_i;
        OFS_EN_CLR: en_q    <= en_q & ~wdata_i;
        OFS_MODE:   mode_q  <= wdata_i;
        OFS_LEVEL:  level_q <= wdata_i;
        OFS_SEL:    sel_q   <= wdata_i[0];
        OFS_TEST:   test_q  <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (ofs)
      OFS_STATUS:             rd_mux = status_i;
      OFS_EN_SET, OFS_EN_CLR: rd_mux = en_q;
      OFS_MODE:               rd_mux = mode_q;
      OFS_LEVEL:              rd_mux = level_q;
      OFS_SEL:                rd_mux = NUM_SRC'(sel_q);
      OFS_TEST:               rd_mux = test_q;
      default:                rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_en_i;
      if (rd_en_i) rdata_q <= rd_mux;
    end
  end

  assign en_o     = en_q;
  assign mode_o   = mode_q;
  assign level_o  = level_q;
  assign sel_o    = sel_q;
  assign test_o   = test_q;
  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
endmodule

// File: rtl/irq_route.sv
module irq_route #(
  parameter int unsigned        NUM_SRC     = 16,
  parameter logic [NUM_SRC-1:0] LOW_OK_MASK = NUM_SRC'(32'h50)
) (
  input  logic [NUM_SRC-1:0] sync_i,
  input  logic [NUM_SRC-1:0] test_i,
  input  logic               sel_i,
  input  logic [NUM_SRC-1:0] level_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic [NUM_SRC-1:0] mode_i,
  output logic [NUM_SRC-1:0] status_o,
  output logic               irq_o,
  output logic               fiq_o
);
  logic [NUM_SRC-1:0] live, pend;

  // polarity only on lines allowed to run active-low
  assign live     = sync_i ^ (level_i & LOW_OK_MASK);
  assign pend     = sel_i ? test_i : live;
  assign status_o = pend & en_i;
  assign irq_o    = |(status_o & ~mode_i);
  assign fiq_o    = |(status_o & mode_i);
endmodule

// File: rtl/irq_fiq_ctrl.sv
module irq_fiq_ctrl
  import irq_fiq_pkg::*;
#(
  parameter int unsigned        NUM_SRC     = 16,
  parameter logic [NUM_SRC-1:0] LOW_OK_MASK = NUM_SRC'(32'h50)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [REG_AW-1:0]  addr_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] rdata_o,
  output logic               rvalid_o,
  output logic               irq_o,
  output logic               fiq_o
);
  logic [NUM_SRC-1:0] sync_src, en_q, mode_q, level_q, test_q, status;
  logic               sel_q;

  irq_sync #(.WIDTH(NUM_SRC)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(src_i), .q_o(sync_src)
  );

  irq_regs #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .status_i(status),
    .en_o(en_q), .mode_o(mode_q), .level_o(level_q), .sel_o(sel_q),
    .test_o(test_q), .rdata_o(rdata_o), .rvalid_o(rvalid_o)
  );

  irq_route #(.NUM_SRC(NUM_SRC), .LOW_OK_MASK(LOW_OK_MASK)) u_route (
    .sync_i(sync_src), .test_i(test_q), .sel_i(sel_q), .level_i(level_q),
    .en_i(en_q), .mode_i(mode_q), .status_o(status), .irq_o(irq_o), .fiq_o(fiq_o)
  );
endmodule

// File: rtl/irq_fiq_ctrl_chk.sv
module irq_fiq_ctrl_chk
  import irq_fiq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic               rd_en_i,
  input logic [REG_AW-1:0]  addr_i,
  input logic [NUM_SRC-1:0] wdata_i,
  input logic               rvalid_o,
  input logic               irq_o,
  input logic               fiq_o,
  input logic [NUM_SRC-1:0] en_q,
  input logic [NUM_SRC-1:0] status
);
  AST_RVALID_AFTER_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rvalid_o); // R9

  AST_NO_RVALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rvalid_o); // R9

  AST_EN_SET_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFS_EN_SET) |=> ((en_q & $past(wdata_i)) == $past(wdata_i))); // R1

  AST_EN_CLR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFS_EN_CLR) |=> ((en_q & $past(wdata_i)) == '0)); // R2

  AST_STATUS_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status & ~en_q) == '0); // R3

  AST_QUIET_WHEN_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0) |-> (!irq_o && !fiq_o)); // R4
endmodule

bind irq_fiq_ctrl irq_fiq_ctrl_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .rvalid_o(rvalid_o), .irq_o(irq_o),
  .fiq_o(fiq_o), .en_q(en_q), .status(status)
);

// File: tb/sim_irq_fiq_ctrl.sv
`timescale 1ns/1ps
module sim_irq_fiq_ctrl;
  localparam int unsigned N = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] src = '0, wdata = '0, rdata;
  logic wr_en = 1'b0, rd_en = 1'b0, rvalid, irq, fiq;
  logic [2:0] addr = '0;
  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [N-1:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  irq_fiq_ctrl #(.NUM_SRC(N)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid),
    .irq_o(irq), .fiq_o(fiq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [N-1:0] e, input string req);
    @(negedge clk); addr = a; rd_en = 1'b1;
    exp_q.push_back(e); tag_q.push_back(req);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic outs(string req, logic ei, logic ef);
    check({req, " irq"}, 32'(irq), 32'(ei));
    check({req, " fiq"}, 32'(fiq), 32'(ef));
  endtask

  // monitor: pops expected read data when the design returns it
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) check("R9 unexpected rvalid", 32'd1, 32'd0);
      else check(tag_q.pop_front(), 32'(rdata), 32'(exp_q.pop_front()));
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    outs("R6 reset", 1'b0, 1'b0);
    check("R6 rvalid", 32'(rvalid), 32'd0);
    rst_n = 1'b1;
    rd(3'd1, '0, "R6 enable");
    rd(3'd3, '0, "R6 mode");
    rd(3'd4, '0, "R6 level");
    rd(3'd5, '0, "R6 select");
    rd(3'd6, '0, "R6 test");
    rd(3'd0, '0, "R3 status reset");
    rd(3'd7, '0, "R9 unmapped");
    @(negedge clk);
    check("R9 rvalid idle", 32'(rvalid), 32'd0);

    src = 16'h0003;
    repeat (3) @(negedge clk);
    rd(3'd0, '0, "R3 status none enabled");
    outs("R4 masked", 1'b0, 1'b0);

    wr(3'd1, 16'h0001);
    outs("R4 irq route", 1'b1, 1'b0);
    rd(3'd0, 16'h0001, "R3 status");
    rd(3'd1, 16'h0001, "R1 mask");
    wr(3'd1, 16'h0100);
    rd(3'd2, 16'h0101, "R1 set keeps others");
    wr(3'd2, 16'h0001);
    rd(3'd1, 16'h0100, "R2 clear keeps others");
    outs("R2 cleared source", 1'b0, 1'b0);

    // synchronizer latency on bit 8
    @(negedge clk); src = 16'h0103;
    @(negedge clk); check("R8 after one edge", 32'(irq), 32'd0);
    @(negedge clk); check("R8 after two edges", 32'(irq), 32'd1);

    wr(3'd3, 16'h0100);
    outs("R4 fiq route", 1'b0, 1'b1);
    rd(3'd3, 16'h0100, "R4 mode readback");
    wr(3'd3, 16'h0000);
    outs("R4 back to irq", 1'b1, 1'b0);

    // bit4 may invert, bit0 may not
    wr(3'd4, 16'h0011);
    rd(3'd4, 16'h0011, "R5 level readback");
    wr(3'd1, 16'h0011);
    rd(3'd0, 16'h0111, "R5 active-low and ignored bit");
    src = 16'h0113;
    repeat (3) @(negedge clk);
    rd(3'd0, 16'h0101, "R5 active-low released");

    wr(3'd6, 16'h0022);
    wr(3'd5, 16'h0001);
    outs("R7 test source no enabled", 1'b0, 1'b0);
    rd(3'd0, 16'h0000, "R7 test bypasses polarity");
    wr(3'd1, 16'h0002);
    outs("R7 test source drives irq", 1'b1, 1'b0);
    rd(3'd0, 16'h0002, "R7 status from test");
    wr(3'd5, 16'h0000);
    rd(3'd5, 16'h0000, "R7 select readback");

    wr(3'd2, 16'hFFFF);
    rd(3'd1, 16'h0000, "R2 mask all");
    rd(3'd0, 16'h0000, "R2 status after mask all");
    outs("R2 mask all", 1'b0, 1'b0);

    repeat (3) @(negedge clk);
    check("R9 all reads returned", 32'(exp_q.size()), 32'd0);
    finish_run();
  end
endmodule